// File: doc/BRIEF.md
# Grouped Dual-Channel DAC Latch Update Controller

This block decides when two DAC channels copy their software-written data registers into the output latches that feed the converters. Software writes a data register and a control register for each channel through a simple write bus. The control register holds a conversion-enable bit and a load-select field. Channel 0's control register also holds a group bit. Each output latch drives a code to its converter, and each channel gives a one-cycle strobe in the cycle its latch takes a new value.

When the channels are not grouped, each channel follows its own load-select field and its own enable bit. Grouping makes the pair behave as one unit. Channel 1's load-select field picks the single trigger for both channels. Both data registers must be written after the previous update before a load can happen, and both latches then load in the same clock cycle. Two trigger inputs come from outside the block: a timer compare output and a second external trigger. Each is synchronized, and only its rising edge counts as a trigger.

Top module: `dac_group_latch`

## Requirements
- R1: After reset both output latches, both data registers, both written flags, both control registers and both strobes are zero, so grouping is off.
- R2: Write decode: address 0 is the channel 0 data register and address 1 the channel 1 data register. Addresses 2 and 3 are the channel 0 and channel 1 control registers. In a control word, bit 0 is the enable, bits 2:1 are the load-select and bit 3 is the group bit. With grouping off, an enabled channel whose load-select is 0 or 1 loads its latch and raises its strobe at the clock edge after the edge that wrote its data register.
- R3: With grouping off, each channel uses only its own load-select and enable, and never waits on the other channel's written flag. The group bit written to channel 1 has no effect.
- R4: With grouping on, channel 1's load-select picks the trigger for both channels. Channel 0's load-select does not take part in trigger selection.
- R5: With grouping on, both strobes rise in the same cycle and both latches load at the same edge.
- R6: With grouping on, both data registers must be written after the last update before any load happens. A write of an unchanged value still counts.
- R7: With grouping on and either enable bit at 0, neither latch changes. Setting the missing enable later releases an update that was held back.
- R8: Load-select 2 selects the timer input and 3 selects the external trigger. Each input passes through two synchronizing flip-flops, and one load happens per rising edge. With grouping off, a trigger loads the latch even when no data write has come in since the last update.
- R9: A data write that lands in the same cycle as an update does not reach the latch at that edge. It sets the channel's written flag again for the next update.
- R10: With grouping on, if either load-select is 0, neither latch changes, even after both data writes and a trigger. Load-select 1 under grouping loads at the edge after the second data write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0,1 data; 2,3 control) |
| wr_data | input | DATA_W (12) | Write data |
| tmr_cmp_i | input | 1 | Timer compare output, asynchronous |
| ext_trig_i | input | 1 | External trigger, asynchronous |
| code0_o | output | DATA_W (12) | Channel 0 latched code |
| code1_o | output | DATA_W (12) | Channel 1 latched code |
| upd0_o | output | 1 | Channel 0 latch-update strobe |
| upd1_o | output | 1 | Channel 1 latch-update strobe |

## Verification
The bench runs each mode in turn. Ungrouped write-triggered loads are checked at an exact cycle. Opposing trigger pulses on two ungrouped channels show that each channel follows only its own source. Under grouping, a pulse on the source that only channel 0 selects must do nothing, while channel 1's source updates both channels. A single data write followed by a trigger, a disabled channel, and a zero load-select field must each leave the latches alone. Four back-to-back writes show that a write arriving at an update edge re-arms the next update, and that the value it wrote does not leak into the current load.

// File: rtl/dgl_pkg.sv
package dgl_pkg;
   typedef enum logic [1:0] {
      LS_WRITE  = 2'd0,
      LS_SECOND = 2'd1,
      LS_TIMER  = 2'd2,
      LS_EXT    = 2'd3
   } lsel_e;

   typedef struct packed {
      logic  grp;
      lsel_e lsel;
      logic  en;
   } ctrl_t;

   localparam int unsigned CTRL_W   = 4;
   localparam int unsigned ADDR_W   = 2;
   localparam logic [1:0]  A_DATA0  = 2'd0;
   localparam logic [1:0]  A_DATA1  = 2'd1;
   localparam logic [1:0]  A_CTRL0  = 2'd2;
   localparam logic [1:0]  A_CTRL1  = 2'd3;
endpackage

// File: rtl/dgl_edge_sync.sv
module dgl_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic rise_o
);
   localparam int unsigned SH_W = STAGES + 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("dgl_edge_sync: STAGES must be at least 2");
   end

   logic [SH_W-1:0] sh_q;

   always_ff @(posedge clk) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[SH_W-2:0], async_i};
   end

   assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

   // R8: a level held high yields exactly one trigger cycle
   p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);
endmodule

// File: rtl/dgl_chan.sv
module dgl_chan
   import dgl_pkg::*;
#(
   parameter int unsigned DATA_W  = 12,
   parameter bit          HAS_GRP = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              data_we,
   input  logic              ctrl_we,
   input  logic [DATA_W-1:0] wdata,
   input  logic              fire,
   output ctrl_t             ctrl_o,
   output logic              flag_o,
   output logic [DATA_W-1:0] code_o,
   output logic              upd_o
);
   if (DATA_W < CTRL_W) begin : g_bad_width
      $error("dgl_chan: DATA_W must hold a control word");
   end

   logic [DATA_W-1:0] data_q;
   logic              en_q;
   lsel_e             lsel_q;
   logic              grp_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_q <= '0;
         en_q   <= 1'b0;
         lsel_q <= LS_WRITE;
      end else begin
         if (data_we) data_q <= wdata;
         if (ctrl_we) begin
            en_q   <= wdata[0];
            lsel_q <= lsel_e'(wdata[2:1]);
         end
      end
   end

   if (HAS_GRP) begin : g_grp
      always_ff @(posedge clk) begin
         if (!rst_n)       grp_q <= 1'b0;
         else if (ctrl_we) grp_q <= wdata[3];
      end
   end else begin : g_no_grp
      logic unused_grp_bit;
      assign unused_grp_bit = wdata[3];
      assign grp_q = 1'b0;
   end

   // written-since-update flag; a write at the update edge re-arms it
   always_ff @(posedge clk) begin
      if (!rst_n)       flag_o <= 1'b0;
      else if (data_we) flag_o <= 1'b1;
      else if (fire)    flag_o <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         code_o <= '0;
         upd_o  <= 1'b0;
      end else begin
         upd_o <= fire;
         if (fire) code_o <= data_q;
      end
   end

   assign ctrl_o = '{grp: grp_q, lsel: lsel_q, en: en_q};

   // R9: an update with no write at that edge drops the flag
   p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !data_we) |=> !flag_o);
   // R9: a write always leaves the flag set
   p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      data_we |=> flag_o);
   // R5: the latch only moves together with its strobe
   p_latch_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_o |-> $stable(code_o));
endmodule

// File: rtl/dgl_upd_ctrl.sv
module dgl_upd_ctrl
   import dgl_pkg::*;
(
   input  ctrl_t ctrl0,
   input  ctrl_t ctrl1,
   input  logic  flag0,
   input  logic  flag1,
   input  logic  tmr_rise,
   input  logic  ext_rise,
   output logic  grp_on,
   output logic  fire0,
   output logic  fire1
);
   function automatic logic src_hit(lsel_e s, logic flag, logic tr, logic er);
      case (s)
         LS_TIMER: return tr;
         LS_EXT:   return er;
         default:  return flag;
      endcase
   endfunction

   logic grp_ready;
   logic grp_fire;

   always_comb begin
      grp_on    = ctrl0.grp;
      grp_ready = ctrl0.en && ctrl1.en &&
                  (ctrl0.lsel != LS_WRITE) && (ctrl1.lsel != LS_WRITE) &&
                  flag0 && flag1;
      grp_fire  = grp_ready && src_hit(ctrl1.lsel, 1'b1, tmr_rise, ext_rise);
      if (grp_on) begin
         fire0 = grp_fire;
         fire1 = grp_fire;
      end else begin
         fire0 = ctrl0.en && src_hit(ctrl0.lsel, flag0, tmr_rise, ext_rise);
         fire1 = ctrl1.en && src_hit(ctrl1.lsel, flag1, tmr_rise, ext_rise);
      end
   end
endmodule

// File: rtl/dac_group_latch.sv
module dac_group_latch
   import dgl_pkg::*;
#(
   parameter int unsigned DATA_W      = 12,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              tmr_cmp_i,
   input  logic              ext_trig_i,
   output logic [DATA_W-1:0] code0_o,
   output logic [DATA_W-1:0] code1_o,
   output logic              upd0_o,
   output logic              upd1_o
);
   localparam int unsigned NTRIG = 2;

   logic [NTRIG-1:0] trig_raw;
   logic [NTRIG-1:0] trig_rise;
   ctrl_t            ctrl0, ctrl1;
   logic             flag0, flag1;
   logic             fire0, fire1;
   logic             grp_on;

   assign trig_raw = {ext_trig_i, tmr_cmp_i};

   for (genvar t = 0; t < NTRIG; t++) begin : g_sync
      dgl_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
         .clk     (clk),
         .rst_n   (rst_n),
         .async_i (trig_raw[t]),
         .rise_o  (trig_rise[t])
      );
   end

   dgl_chan #(.DATA_W(DATA_W), .HAS_GRP(1'b1)) i_ch0 (
      .clk     (clk),
      .rst_n   (rst_n),
      .data_we (wr_en && (wr_addr == A_DATA0)),
      .ctrl_we (wr_en && (wr_addr == A_CTRL0)),
      .wdata   (wr_data),
      .fire    (fire0),
      .ctrl_o  (ctrl0),
      .flag_o  (flag0),
      .code_o  (code0_o),
      .upd_o   (upd0_o)
   );

   dgl_chan #(.DATA_W(DATA_W), .HAS_GRP(1'b0)) i_ch1 (
      .clk     (clk),
      .rst_n   (rst_n),
      .data_we (wr_en && (wr_addr == A_DATA1)),
      .ctrl_we (wr_en && (wr_addr == A_CTRL1)),
      .wdata   (wr_data),
      .fire    (fire1),
      .ctrl_o  (ctrl1),
      .flag_o  (flag1),
      .code_o  (code1_o),
      .upd_o   (upd1_o)
   );

   dgl_upd_ctrl i_ctrl (
      .ctrl0    (ctrl0),
      .ctrl1    (ctrl1),
      .flag0    (flag0),
      .flag1    (flag1),
      .tmr_rise (trig_rise[0]),
      .ext_rise (trig_rise[1]),
      .grp_on   (grp_on),
      .fire0    (fire0),
      .fire1    (fire1)
   );

   // R5: under grouping the two strobes never split
   p_atomic_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(grp_on) |-> (upd0_o == upd1_o));
   // R6: a grouped load needs both written flags
   p_both_written_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(grp_on) && upd0_o) |-> $past(flag0 && flag1));
   // R7: a cleared enable under grouping blocks both latches
   p_enable_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(grp_on && !(ctrl0.en && ctrl1.en)) |-> (!upd0_o && !upd1_o));
   // R10: a zero load-select under grouping blocks both latches
   p_zero_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(grp_on && ((ctrl0.lsel == LS_WRITE) || (ctrl1.lsel == LS_WRITE)))
      |-> (!upd0_o && !upd1_o));
endmodule

// File: tb/test_dac_group_latch.sv
module test_dac_group_latch;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [11:0] wr_data = '0;
   logic        tmr_cmp_i = 1'b0;
   logic        ext_trig_i = 1'b0;
   logic [11:0] code0_o, code1_o;
   logic        upd0_o, upd1_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   typedef struct {
      logic [1:0]  mask;
      logic [11:0] c0;
      logic [11:0] c1;
      string       tag;
   } exp_t;
   exp_t sb[$];

   always #2 clk = ~clk;

   dac_group_latch i_dac_group_latch (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .tmr_cmp_i(tmr_cmp_i), .ext_trig_i(ext_trig_i),
      .code0_o(code0_o), .code1_o(code1_o), .upd0_o(upd0_o), .upd1_o(upd1_o)
   );

   task automatic chk(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic expect_upd(logic [1:0] m, logic [11:0] c0, logic [11:0] c1, string tag);
      exp_t e;
      e.mask = m; e.c0 = c0; e.c1 = c1; e.tag = tag;
      sb.push_back(e);
   endtask

   // monitor: every strobe must match the next expected item
   always @(negedge clk) begin
      if (rst_n && (upd0_o || upd1_o)) begin
         if (sb.size() == 0) begin
            chk(1'b0, "unexpected update", {upd1_o, upd0_o}, 0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            chk({upd1_o, upd0_o} == e.mask, {e.tag, " mask"}, {upd1_o, upd0_o}, e.mask);
            chk(code0_o == e.c0, {e.tag, " code0"}, code0_o, e.c0);
            chk(code1_o == e.c1, {e.tag, " code1"}, code1_o, e.c1);
         end
      end
   end

   task automatic wr(logic [1:0] a, logic [11:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_tmr();
      tmr_cmp_i = 1'b1; idle(3); tmr_cmp_i = 1'b0; idle(6);
   endtask

   task automatic pulse_ext();
      ext_trig_i = 1'b1; idle(3); ext_trig_i = 1'b0; idle(6);
   endtask

   initial begin
      idle(3);
      chk(code0_o == 0 && code1_o == 0, "R1 reset codes", code0_o, 0);
      chk(!upd0_o && !upd1_o, "R1 reset strobes", {upd1_o, upd0_o}, 0);
      rst_n = 1'b1;
      idle(2);

      // R2: ungrouped, load-select 0, exact cycle
      wr(2'd2, 12'h001);
      expect_upd(2'b01, 12'h123, 12'h000, "R2 write load");
      wr(2'd0, 12'h123);
      chk(!upd0_o && code0_o == 0, "R2 not before next edge", code0_o, 0);
      @(negedge clk);
      chk(upd0_o && code0_o == 12'h123, "R2 one edge after write", code0_o, 12'h123);
      idle(3);

      // R3: channel 1 group bit ignored, channels independent
      wr(2'd3, 12'h009);
      expect_upd(2'b10, 12'h123, 12'h456, "R3 ch1 alone");
      wr(2'd1, 12'h456);
      idle(3);
      expect_upd(2'b01, 12'h321, 12'h456, "R3 ch0 alone");
      wr(2'd0, 12'h321);
      idle(3);

      // R8: ungrouped triggers, each channel its own source
      wr(2'd2, 12'h005);
      wr(2'd3, 12'h007);
      wr(2'd0, 12'hAAA);
      wr(2'd1, 12'h555);
      idle(3);
      expect_upd(2'b10, 12'h321, 12'h555, "R8 ext on ch1");
      pulse_ext();
      expect_upd(2'b01, 12'hAAA, 12'h555, "R8 timer on ch0");
      pulse_tmr();
      expect_upd(2'b01, 12'hAAA, 12'h555, "R8 trigger without write");
      pulse_tmr();

      // R4/R5: grouped, channel 1 selects the timer
      wr(2'd3, 12'h005);
      wr(2'd2, 12'h00F);
      wr(2'd0, 12'h0F0);
      wr(2'd1, 12'h00F);
      pulse_ext();      // R4: channel 0's source must not trigger
      expect_upd(2'b11, 12'h0F0, 12'h00F, "R5 grouped timer load");
      pulse_tmr();

      // R6: both writes required, unchanged value counts
      wr(2'd0, 12'h111);
      pulse_tmr();
      wr(2'd1, 12'h00F);
      expect_upd(2'b11, 12'h111, 12'h00F, "R6 after both writes");
      pulse_tmr();

      // R7: enable gate under grouping
      wr(2'd3, 12'h002);
      wr(2'd0, 12'h222);
      wr(2'd1, 12'h333);
      idle(5);
      expect_upd(2'b11, 12'h222, 12'h333, "R7 released by enable");
      wr(2'd3, 12'h003);
      idle(3);

      // R9/R10: grouped load-select 1, write at update edge
      expect_upd(2'b11, 12'h444, 12'h555, "R10 second-write load");
      expect_upd(2'b11, 12'h666, 12'h777, "R9 re-armed load");
      wr(2'd0, 12'h444);
      wr(2'd1, 12'h555);
      wr(2'd0, 12'h666);
      wr(2'd1, 12'h777);
      idle(3);

      // R10: zero load-select under grouping blocks both
      wr(2'd2, 12'h009);
      wr(2'd0, 12'h888);
      wr(2'd1, 12'h999);
      pulse_tmr();
      chk(code0_o == 12'h666 && code1_o == 12'h777, "R10 zero select holds", code0_o, 12'h666);
      expect_upd(2'b11, 12'h888, 12'h999, "R3 ungroup releases both");
      wr(2'd2, 12'h001);
      idle(4);

      chk(sb.size() == 0, "all expected updates seen", sb.size(), 0);
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         chk(1'b0, "watchdog", 0, 1);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule